// File: doc/BRIEF.md
# MDIO Clause 45 Indirect Access Master

This block is a memory-mapped management master for the two-wire MDIO bus, using the Clause 45 indirect addressing scheme. Software first places a 16-bit register address in a staging register. It then writes a command word that names the port, the device and the operation. That single command write makes the block send two frames back to back. The first is an address frame carrying the staged register address. The second is a write frame or a read frame aimed at the same port and device.

Software learns that the transaction is complete by polling a busy flag in the command register. When a read finishes, the returned data appears in the low half of that register. A separate valid flag shows whether the addressed device answered during the turnaround. The management clock comes from a divider of the system clock, and its ratio is a parameter.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset, both registers read as zero, MDC is low and the block does not drive MDIO.
- R2: Offset 0x8 holds the register address. Only write-data bits 15:0 are kept, and reading offset 0x8 returns those bits with bits 31:16 as zero.
- R3: A write to offset 0x0 while idle starts a transaction when bits 28:26 hold 5 (write) or 7 (read). Busy is set from the next cycle. The port is taken from bits 20:16, the device from bits 25:21, and the write data from bits 15:0.
- R4: A command write whose bits 28:26 hold any value other than 5 or 7 is ignored. Busy stays clear, MDC does not toggle and MDIO is not driven.
- R5: A command write that arrives while busy is ignored. The frames in progress and the busy duration are unchanged.
- R6: The first frame, sent MSB first, is 32 ones, start 00, opcode 00, port (5 bits), device (5 bits), turnaround 10, then the staged 16-bit register address.
- R7: For a write, the second frame is 32 ones, 00, opcode 01, port, device, 10, then the 16 write-data bits.
- R8: For a read, the second frame uses opcode 11. The master drives only its first 46 bits and releases MDIO for both turnaround bits and the 16 data bits.
- R9: MDC has a period of 2*CLK_DIV clocks, with 128 rising edges per transaction. Busy stays set for exactly 256*CLK_DIV clocks, counted from the command edge, and covers both frames.
- R10: Offset 0x0 reads with busy at bit 30, read-valid at bit 29 and data at bits 15:0; all other bits read as 0. A read completes with read-valid set and the sampled data (MSB first, taken on MDC rising edges) only if MDIO is low at the second turnaround bit. Otherwise read-valid is clear and the data reads as 0xFFFF.
- R11: Read-valid is cleared when a command is accepted, and it stays clear after a write transaction.
- R12: While idle, MDC is low and MDIO output-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the register at bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The bench builds the block with CLK_DIV=2. This keeps one transaction at 512 clocks, which is short enough to sweep all eight operation codes and both read and write paths. The sweep covers acknowledged and unacknowledged reads and a spread of port, device, address and data values. At this ratio the exact busy length and the count of MDC edges can be checked on every transaction. A command can also be injected partway through a transaction to show that it is ignored.

// File: rtl/mdio_c45_master.sv
module mdio_c45_master #(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [3:0] CMD_OFS = 4'h0;
  localparam logic [3:0] RADDR_OFS = 4'h8;
  localparam logic [5:0] LAST_BIT = 6'd63;
  localparam logic [5:0] TA1_BIT = 6'd46;
  localparam logic [5:0] TA2_BIT = 6'd47;
  localparam logic [5:0] DATA_BIT = 6'd48;

  logic          busy_q, rvalid_q, second_q, mdc_q, ta_ok_q, is_rd_q;
  logic [15:0]   raddr_q, data_q, rd_sh_q, wdat_q;
  logic [4:0]    prt_q, dev_q;
  logic [5:0]    bit_q;
  logic [63:0]   sh_q;
  logic [DW-1:0] div_q;

  function automatic logic [63:0] mk_frame(input logic [1:0] opc, input logic [4:0] p,
                                           input logic [4:0] d, input logic [15:0] v);
    return {32'hFFFF_FFFF, 2'b00, opc, p, d, 2'b10, v};
  endfunction

  wire [2:0] op_f  = bus_wdata[28:26];
  wire start = bus_we && bus_addr == CMD_OFS && !busy_q && (op_f == 3'd5 || op_f == 3'd7);
  wire tick  = busy_q && div_q == DW'(CLK_DIV - 1);
  wire rise  = tick && !mdc_q;
  wire fall  = tick && mdc_q;
  wire rd_released = second_q && is_rd_q && bit_q >= TA1_BIT;

  logic unused_bits;
  assign unused_bits = ^bus_wdata[31:29];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; rvalid_q <= 1'b0; second_q <= 1'b0; mdc_q <= 1'b0;
      ta_ok_q <= 1'b0; is_rd_q <= 1'b0;
      raddr_q <= '0; data_q <= '0; rd_sh_q <= '0; wdat_q <= '0;
      prt_q <= '0; dev_q <= '0; bit_q <= '0; sh_q <= '0; div_q <= '0;
    end else begin
      if (bus_we && bus_addr == RADDR_OFS)
        raddr_q <= bus_wdata[15:0];
      if (start) begin
        busy_q   <= 1'b1;
        rvalid_q <= 1'b0;
        second_q <= 1'b0;
        ta_ok_q  <= 1'b0;
        mdc_q    <= 1'b0;
        div_q    <= '0;
        bit_q    <= '0;
        prt_q    <= bus_wdata[20:16];
        dev_q    <= bus_wdata[25:21];
        wdat_q   <= bus_wdata[15:0];
        is_rd_q  <= op_f == 3'd7;
        sh_q     <= mk_frame(2'b00, bus_wdata[20:16], bus_wdata[25:21], raddr_q);
      end else if (busy_q) begin
        if (tick) begin
          div_q <= '0;
          mdc_q <= ~mdc_q;
        end else begin
          div_q <= div_q + 1'b1;
        end
        if (rise && second_q && is_rd_q) begin
          if (bit_q == TA2_BIT) ta_ok_q <= ~mdio_i;
          if (bit_q >= DATA_BIT) rd_sh_q <= {rd_sh_q[14:0], mdio_i};
        end
        if (fall) begin
          if (bit_q == LAST_BIT) begin
            bit_q <= '0;
            if (!second_q) begin
              second_q <= 1'b1;
              sh_q <= mk_frame(is_rd_q ? 2'b11 : 2'b01, prt_q, dev_q, wdat_q);
            end else begin
              busy_q <= 1'b0;
              if (is_rd_q) begin
                rvalid_q <= ta_ok_q;
                data_q   <= ta_ok_q ? rd_sh_q : 16'hFFFF;
              end
            end
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[62:0], 1'b1};
          end
        end
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = sh_q[63];
  assign mdio_oe = busy_q && !rd_released;
  assign bus_rdata = (bus_addr == RADDR_OFS) ? {16'h0, raddr_q} :
                     (bus_addr == CMD_OFS)   ? {1'b0, busy_q, rvalid_q, 13'h0, data_q} :
                     32'h0;
endmodule

module mdio_c45_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        busy,
  input logic        rvalid,
  input logic        mdc,
  input logic        mdio_oe,
  input logic [4:0]  prt,
  input logic [4:0]  dev
);
  wire cmd_here = bus_we && bus_addr == 4'h0;
  wire good_op  = bus_wdata[28:26] == 3'd5 || bus_wdata[28:26] == 3'd7;

  // R3
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_here && !busy && good_op |=> busy);
  // R4
  bad_op_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_here && !busy && !good_op |=> !busy && !mdc && !mdio_oe);
  // R5
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_here && busy |=> $stable(prt) && $stable(dev));
  // R11
  rvalid_clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !rvalid);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc && !mdio_oe);
  // R9
  mdc_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc) |-> $past(busy));
endmodule

bind mdio_c45_master mdio_c45_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .busy(busy_q), .rvalid(rvalid_q), .mdc(mdc),
  .mdio_oe(mdio_oe), .prt(prt_q), .dev(dev_q)
);

// File: tb/sim_mdio_c45_master.sv
module sim_mdio_c45_master;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails = 0;
  int rise_cnt = 0;
  logic [63:0] f0_o, f0_oe, f1_o, f1_oe;
  logic        phy_rd = 1'b0;
  logic        phy_ack = 1'b0;
  logic [15:0] phy_val = '0;

  mdio_c45_master #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #2 clk = ~clk;

  always @(posedge mdc) begin
    if (rise_cnt < 64) begin
      f0_o = {f0_o[62:0], mdio_o}; f0_oe = {f0_oe[62:0], mdio_oe};
    end else begin
      f1_o = {f1_o[62:0], mdio_o}; f1_oe = {f1_oe[62:0], mdio_oe};
    end
    rise_cnt = rise_cnt + 1;
  end

  always @(negedge mdc) begin
    if (rise_cnt >= 64 && phy_rd && (rise_cnt % 64) == 47)
      mdio_i = !phy_ack;
    else if (rise_cnt >= 64 && phy_rd && (rise_cnt % 64) >= 48)
      mdio_i = phy_val[63 - (rise_cnt % 64)];
    else
      mdio_i = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 4'h0;
  endtask

  task automatic run(input logic [2:0] op, input logic [4:0] prt, input logic [4:0] dev,
                     input logic [15:0] ra, input logic [15:0] wd, input logic ack,
                     input logic [15:0] rv, input logic collide);
    int n;
    logic [63:0] e0, e1;
    bus_write(4'h8, {16'hA5C3 ^ {ra, 16'h0} >> 16, ra});
    bus_addr = 4'h8; #0;
    // R2
    chk("R2 raddr readback", {32'h0, bus_rdata}, {48'h0, ra});
    bus_addr = 4'h0;
    phy_rd = (op == 3'd7); phy_ack = ack; phy_val = rv;
    rise_cnt = 0; f0_o = '0; f0_oe = '0; f1_o = '0; f1_oe = '0;
    bus_write(4'h0, {3'b0, op, dev, prt, wd});
    // R3
    chk("R3 busy after command", {63'h0, bus_rdata[30]}, 64'h1);
    n = 0;
    while (bus_rdata[30] && n < 4000) begin
      n++;
      @(negedge clk);
      if (collide && n == 100) begin
        bus_we = 1'b1;
        bus_wdata = {3'b0, 3'd7, ~dev, ~prt, ~wd};
      end else begin
        bus_we = 1'b0;
      end
      #0;
    end
    // R9 / R5
    chk(collide ? "R5 busy length with collision" : "R9 busy length", n, 256 * DIV);
    chk("R9 mdc rising edges", rise_cnt, 128);
    e0 = {32'hFFFF_FFFF, 2'b00, 2'b00, prt, dev, 2'b10, ra};
    // R6
    chk("R6 address frame", f0_o, e0);
    chk("R6 address frame drive", f0_oe, {64{1'b1}});
    if (op == 3'd5) begin
      e1 = {32'hFFFF_FFFF, 2'b00, 2'b01, prt, dev, 2'b10, wd};
      // R7
      chk("R7 write frame", f1_o, e1);
      chk("R7 write frame drive", f1_oe, {64{1'b1}});
      // R11
      chk("R11 rvalid after write", {62'h0, bus_rdata[30:29]}, 64'h0);
    end else begin
      e1 = {32'hFFFF_FFFF, 2'b00, 2'b11, prt, dev, 2'b10, 16'h0};
      // R8
      chk("R8 read frame head", {18'h0, f1_o[63:18]}, {18'h0, e1[63:18]});
      chk("R8 read frame release", f1_oe, {{46{1'b1}}, 18'h0});
      // R10
      chk("R10 read status/data", {32'h0, bus_rdata},
          ack ? {32'h0, 3'b001, 13'h0, rv} : {32'h0, 16'h0, 16'hFFFF});
    end
    // R12
    chk("R12 idle pins", {62'h0, mdc, mdio_oe}, 64'h0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    bus_addr = 4'h0; #0;
    chk("R1 cmd reg reset", {32'h0, bus_rdata}, 64'h0);
    bus_addr = 4'h8; #0;
    chk("R1 raddr reg reset", {32'h0, bus_rdata}, 64'h0);
    chk("R1 pins reset", {62'h0, mdc, mdio_oe}, 64'h0);
    bus_addr = 4'h0;

    // R4: every op code other than 5 and 7
    for (int op = 0; op < 8; op++) begin
      if (op != 5 && op != 7) begin
        int act;
        rise_cnt = 0;
        act = 0;
        bus_write(4'h0, {3'b0, 3'(op), 5'd3, 5'd9, 16'h1234});
        for (int k = 0; k < 12; k++) begin
          if (bus_rdata[30] || mdc || mdio_oe) act = 1;
          @(negedge clk);
        end
        chk("R4 ignored op code", {32'h0, act, rise_cnt}, 64'h0);
      end
    end

    for (int i = 0; i < 8; i++) begin
      logic [2:0] op;
      op = i[0] ? 3'd7 : 3'd5;
      run(op, 5'(i * 7 + 1), 5'(31 - i * 3), 16'(16'h8001 + i * 16'h1357),
          16'(16'hC0DE ^ (i * 16'h0F1F)), i[1], 16'(16'h4A5B + i * 16'h2222), 1'b0);
    end
    run(3'd5, 5'd0, 5'd31, 16'hFFFF, 16'h0000, 1'b1, 16'h0, 1'b0);
    run(3'd7, 5'd31, 5'd0, 16'h0000, 16'hFFFF, 1'b1, 16'h0000, 1'b0);
    run(3'd7, 5'd12, 5'd5, 16'h7E81, 16'h0, 1'b0, 16'h0000, 1'b0);
    // R5
    run(3'd5, 5'd17, 5'd6, 16'h3C3C, 16'h9A9A, 1'b0, 16'h0, 1'b1);
    run(3'd7, 5'd2, 5'd29, 16'h0F0F, 16'h0, 1'b1, 16'hBEEF, 1'b1);

    // R11: a write after a valid read leaves rvalid clear
    run(3'd7, 5'd4, 5'd4, 16'h0001, 16'h0, 1'b1, 16'h1111, 1'b0);
    run(3'd5, 5'd4, 5'd4, 16'h0002, 16'h2222, 1'b0, 16'h0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule